// File: doc/BRIEF.md
# Two-Phase Clock Generator

This block turns a fast fabric clock into a slow, two-phase machine clock. A fractional divider toggles a primary square wave so that its average frequency matches a target rate exactly, even when the fast rate is not an integer multiple of it. The second phase is the primary wave passed through a shift chain of flip-flops. This models a fixed analog delay line as a whole number of fast cycles.

Downstream logic runs on the fast clock. It uses the two level outputs, or the one-cycle rise strobes, as enables. With the default settings a 100 MHz reference gives a 1.5 MHz primary wave. Each half-period is 33 or 34 fast cycles, and the second phase trails the first by 33 fast cycles (330 ns).

Top module: `ckgen_two_phase`

## Requirements
- R1: While `rst` is sampled high at a rising edge of `clk_fast`, all four outputs are 0 after that edge.
- R2: Count rising edges of `clk_fast` from the first one at which `rst` is sampled low, starting at 1. The n-th change of `phase1_o` occurs at edge ceil(n·FAST_HZ / (2·SLOW_HZ)). No change occurs at any other edge.
- R3: Every half-period of `phase1_o` lasts either floor or ceil of FAST_HZ/(2·SLOW_HZ) fast cycles. With the defaults this is 33 or 34.
- R4: After reset `phase1_o` starts at 0, and its first change is a rise to 1.
- R5: After edge k, `phase2_o` equals the value `phase1_o` had after edge k−DELAY_TAPS. It is 0 while k < DELAY_TAPS.
- R6: `phase1_rise_o` is 1 after exactly those edges where `phase1_o` has just gone from 0 to 1. It is therefore never high on two cycles in a row.
- R7: `phase2_rise_o` is 1 after exactly those edges where `phase2_o` has just gone from 0 to 1.
- R8: A reset applied in mid-run flushes the delay chain, so `phase2_o` reads 0 at once. After release, the timing of R2 and R5 restarts from edge 1.
- R9: When FAST_HZ is an exact multiple of 2·SLOW_HZ, every half-period has the same length, FAST_HZ/(2·SLOW_HZ) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| phase1_o | output | 1 | Primary oscillator level |
| phase2_o | output | 1 | Delayed second phase level |
| phase1_rise_o | output | 1 | One-cycle strobe on each rise of phase1_o |
| phase2_rise_o | output | 1 | One-cycle strobe on each rise of phase2_o |

## Verification
A corrupted divider accumulator shows up as a primary edge that lands one or more fast cycles away from the ceil schedule. That error appears at the next toggle, within 34 cycles. A stuck or misaligned tap in the delay chain makes `phase2_o` disagree with the primary history as soon as the first primary edge reaches the chain output, DELAY_TAPS cycles after that edge. A stale edge-detector register gives a strobe that is missing, doubled or placed on a falling edge. It is visible on the very cycle of the transition.

// File: rtl/ckgen_pkg.sv
package ckgen_pkg;

    // Level and rise strobe of one clock phase
    typedef struct packed {
        logic level;
        logic rise;
    } phase_t;

    localparam int unsigned NUM_PHASES = 2;

    // Greatest common divisor, used to reduce the divider ratio
    function automatic int unsigned gcd_f(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Toggle step of the reduced fractional divider
    function automatic int unsigned step_f(input int unsigned fast_hz, input int unsigned slow_hz);
        return (2 * slow_hz) / gcd_f(2 * slow_hz, fast_hz);
    endfunction

    // Modulus of the reduced fractional divider
    function automatic int unsigned mod_f(input int unsigned fast_hz, input int unsigned slow_hz);
        return fast_hz / gcd_f(2 * slow_hz, fast_hz);
    endfunction

endpackage

// File: rtl/ckgen_divider.sv
module ckgen_divider #(
    parameter int unsigned STEP = 3,
    parameter int unsigned MOD  = 100
) (
    input  logic clk,
    input  logic rst,
    output logic osc_o
);
    localparam int unsigned ACC_W = $clog2(MOD + STEP + 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             wrap;

    always_comb begin
        sum  = acc_q + ACC_W'(STEP);
        wrap = (sum >= ACC_W'(MOD));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            osc_o <= 1'b0;
        end else if (wrap) begin
            acc_q <= sum - ACC_W'(MOD);
            osc_o <= ~osc_o;
        end else begin
            acc_q <= sum;
        end
    end
endmodule

// File: rtl/ckgen_delay_line.sv
module ckgen_delay_line #(
    parameter int unsigned TAPS = 33
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [TAPS-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < int'(TAPS); i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign dout = chain_q[TAPS-1];
endmodule

// File: rtl/ckgen_edge_detect.sv
module ckgen_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/ckgen_two_phase.sv
module ckgen_two_phase
    import ckgen_pkg::*;
#(
    parameter int unsigned FAST_HZ    = 100_000_000,
    parameter int unsigned SLOW_HZ    = 1_500_000,
    parameter int unsigned DELAY_TAPS = 33
) (
    input  logic clk_fast,
    input  logic rst,
    output logic phase1_o,
    output logic phase2_o,
    output logic phase1_rise_o,
    output logic phase2_rise_o
);
    localparam int unsigned STEP = step_f(FAST_HZ, SLOW_HZ);
    localparam int unsigned MOD  = mod_f(FAST_HZ, SLOW_HZ);

    logic                  osc;
    logic                  delayed;
    logic [NUM_PHASES-1:0] lvl;
    phase_t                ph [NUM_PHASES];

    ckgen_divider #(.STEP(STEP), .MOD(MOD)) div_i (
        .clk   (clk_fast),
        .rst   (rst),
        .osc_o (osc)
    );

    ckgen_delay_line #(.TAPS(DELAY_TAPS)) dly_i (
        .clk  (clk_fast),
        .rst  (rst),
        .din  (osc),
        .dout (delayed)
    );

    assign lvl = {delayed, osc};

    for (genvar g = 0; g < int'(NUM_PHASES); g++) begin : g_phase
        logic r;
        ckgen_edge_detect edge_i (
            .clk   (clk_fast),
            .rst   (rst),
            .level (lvl[g]),
            .rise  (r)
        );
        assign ph[g] = '{level: lvl[g], rise: r};
    end

    assign phase1_o      = ph[0].level;
    assign phase1_rise_o = ph[0].rise;
    assign phase2_o      = ph[1].level;
    assign phase2_rise_o = ph[1].rise;
endmodule

// File: rtl/ckgen_two_phase_chk.sv
module ckgen_two_phase_chk
    import ckgen_pkg::*;
#(
    parameter int unsigned FAST_HZ    = 100_000_000,
    parameter int unsigned SLOW_HZ    = 1_500_000,
    parameter int unsigned DELAY_TAPS = 33
) (
    input logic clk_fast,
    input logic rst,
    input logic phase1_o,
    input logic phase2_o,
    input logic phase1_rise_o,
    input logic phase2_rise_o
);
    localparam int unsigned STEP = step_f(FAST_HZ, SLOW_HZ);
    localparam int unsigned MOD  = mod_f(FAST_HZ, SLOW_HZ);
    localparam int unsigned LO   = MOD / STEP;
    localparam int unsigned HI   = (MOD + STEP - 1) / STEP;

    logic        seen_q;
    logic [31:0] run_q;

    // Length of the current run of equal phase1 samples
    always_ff @(posedge clk_fast) begin
        if (rst) begin
            seen_q <= 1'b0;
            run_q  <= '0;
        end else begin
            seen_q <= phase1_o;
            run_q  <= (phase1_o != seen_q) ? 32'd1 : run_q + 32'd1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk_fast)
        rst |=> (!phase1_o && !phase2_o && !phase1_rise_o && !phase2_rise_o));

    assert_run_upper_R3: assert property (@(posedge clk_fast) disable iff (rst)
        run_q <= HI);

    assert_run_lower_R3: assert property (@(posedge clk_fast) disable iff (rst)
        (phase1_o != seen_q && run_q != 0) |-> run_q >= LO);

    assert_strobe1_edge_R6: assert property (@(posedge clk_fast) disable iff (rst)
        phase1_rise_o |-> (phase1_o && !$past(phase1_o)));

    assert_strobe1_single_R6: assert property (@(posedge clk_fast) disable iff (rst)
        phase1_rise_o |=> !phase1_rise_o);

    assert_strobe2_edge_R7: assert property (@(posedge clk_fast) disable iff (rst)
        phase2_rise_o |-> (phase2_o && !$past(phase2_o)));
endmodule

bind ckgen_two_phase ckgen_two_phase_chk #(
    .FAST_HZ(FAST_HZ), .SLOW_HZ(SLOW_HZ), .DELAY_TAPS(DELAY_TAPS)
) chk_i (
    .clk_fast      (clk_fast),
    .rst           (rst),
    .phase1_o      (phase1_o),
    .phase2_o      (phase2_o),
    .phase1_rise_o (phase1_rise_o),
    .phase2_rise_o (phase2_rise_o)
);

// File: tb/ckgen_two_phase_tb.sv
module ckgen_two_phase_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NREC       = 700;

    localparam int F0 = 100_000_000, S0 = 1_500_000,  D0 = 33;
    localparam int F1 = 100_000_000, S1 = 10_000_000, D1 = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] p1, p2, s1, s2;

    int checks = 0;
    int errors = 0;

    logic r1 [2][0:NREC];
    logic r2 [2][0:NREC];
    logic q1 [2][0:NREC];
    logic q2 [2][0:NREC];

    always #(CLK_PERIOD/2) clk = ~clk;

    ckgen_two_phase #(.FAST_HZ(F0), .SLOW_HZ(S0), .DELAY_TAPS(D0)) dut_i (
        .clk_fast(clk), .rst(rst), .phase1_o(p1[0]), .phase2_o(p2[0]),
        .phase1_rise_o(s1[0]), .phase2_rise_o(s2[0]));

    ckgen_two_phase #(.FAST_HZ(F1), .SLOW_HZ(S1), .DELAY_TAPS(D1)) dut_alt_i (
        .clk_fast(clk), .rst(rst), .phase1_o(p1[1]), .phase2_o(p2[1]),
        .phase1_rise_o(s1[1]), .phase2_rise_o(s2[1]));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R1: reset held, all outputs low on both instances
    task automatic test_reset_state();
        @(negedge clk) rst = 1'b1;
        repeat (3) begin
            @(posedge clk); #1;
            chk({p1, p2, s1, s2} == 8'h00, "R1 outputs during reset",
                int'({p1, p2, s1, s2}), 0);
        end
    endtask

    // Release reset and record NREC cycles; index 0 holds the reset values
    task automatic record_run();
        for (int u = 0; u < 2; u++) begin
            r1[u][0] = 1'b0; r2[u][0] = 1'b0; q1[u][0] = 1'b0; q2[u][0] = 1'b0;
        end
        @(negedge clk) rst = 1'b0;
        for (int k = 1; k <= NREC; k++) begin
            @(posedge clk); #1;
            for (int u = 0; u < 2; u++) begin
                r1[u][k] = p1[u]; r2[u][k] = p2[u];
                q1[u][k] = s1[u]; q2[u][k] = s2[u];
            end
        end
    endtask

    function automatic int toggle_edge(input longint n, input longint f, input longint s);
        return int'((n * f + 2 * s - 1) / (2 * s));
    endfunction

    task automatic check_run(input int u, input int f, input int s, input int d, input string tag);
        int n = 0;
        int last = 0;
        int lo = f / (2 * s);
        int hi = (f + 2 * s - 1) / (2 * s);
        logic ref1;
        for (int k = 1; k <= NREC; k++) begin
            if (r1[u][k] != r1[u][k-1]) begin
                n++;
                chk(k == toggle_edge(n, f, s), {tag, " R2 toggle edge"}, k, toggle_edge(n, f, s));
                if (n == 1)
                    chk(r1[u][k] == 1'b1, {tag, " R4 first change is a rise"}, int'(r1[u][k]), 1);
                else if (lo == hi)
                    chk(k - last == lo, {tag, " R9 constant half-period"}, k - last, lo);
                else
                    chk(k - last == lo || k - last == hi, {tag, " R3 half-period length"}, k - last, hi);
                last = k;
            end
            ref1 = (k >= d) ? r1[u][k-d] : 1'b0;
            chk(r2[u][k] == ref1, {tag, " R5 delayed phase"}, int'(r2[u][k]), int'(ref1));
            chk(q1[u][k] == (r1[u][k] & ~r1[u][k-1]), {tag, " R6 phase1 strobe"},
                int'(q1[u][k]), int'(r1[u][k] & ~r1[u][k-1]));
            chk(q2[u][k] == (r2[u][k] & ~r2[u][k-1]), {tag, " R7 phase2 strobe"},
                int'(q2[u][k]), int'(r2[u][k] & ~r2[u][k-1]));
        end
        chk(toggle_edge(n + 1, f, s) > NREC, {tag, " R2 no missing toggle"}, n, n + 1);
    endtask

    task automatic test_steady();
        record_run();
        check_run(0, F0, S0, D0, "dut0");
        check_run(1, F1, S1, D1, "dut1");
    endtask

    // R8: reset in mid-run while the delayed phase is high, then restart
    task automatic test_midrun_reset();
        while (p2[0] !== 1'b1) @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk(p2[0] == 1'b0, "R8 delay chain flushed", int'(p2[0]), 0);
        chk({p1, p2, s1, s2} == 8'h00, "R8 outputs cleared", int'({p1, p2, s1, s2}), 0);
        record_run();
        check_run(0, F0, S0, D0, "R8 dut0 restart");
        check_run(1, F1, S1, D1, "R8 dut1 restart");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset_state();
        test_steady();
        test_midrun_reset();
        test_reset_state();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule